// File: doc/BRIEF.md
# Byte-Level Two-Wire Bus Master with Clock Stretching

This block is the controller side of a two-wire open-drain serial bus (I2C style) for a system with one master. It never drives a line high. Each of SCL and SDA has an output enable that pulls the line low when set. Both lines are read back through a synchronizer. A host gives one command at a time: a start, a repeated start, a stop, a byte write, or a byte read with a chosen acknowledge answer. The block finishes the command on the wire and then raises a one-cycle completion pulse.

Each bit period is split into four equal quarter phases. A prescaler times the phases, and it is sized from the system clock and target bus rate parameters. Whenever the block releases SCL, it reads the line back and holds its phase timer until SCL is actually high. A slave can therefore stretch any clock pulse by holding SCL low. No sample is taken and no further edge is made until the slave lets go. Software builds whole transactions from these primitives, for example: start, address write, index write, repeated start, address write, data reads, stop.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset both output enables are 0, so both lines are released, and busy and done are 0.
- R2: A command is accepted only when cmd_valid is 1 and busy is 0, and only for the codes 1 (start), 2 (repeated start), 3 (stop), 4 (write byte) and 5 (read byte). Busy rises in the cycle after acceptance. Other codes, and any command offered while busy, are ignored.
- R3: A start or repeated start makes SDA fall while SCL is high. This works from the idle bus and from a bus where SCL is held low. The command ends with SCL and SDA both held low.
- R4: A stop makes SDA rise while SCL is high. The command ends with both output enables 0.
- R5: A write shifts tx_byte out most significant bit first in exactly 9 SCL pulses. SDA changes only while SCL is low, so no start or stop condition appears inside a byte.
- R6: During the ninth pulse of a write the block releases SDA and samples it. At completion slave_nack shows the sampled level: 0 means acknowledged and 1 means refused.
- R7: A read releases SDA for 8 pulses and assembles rx_byte most significant bit first. In the ninth pulse it pulls SDA low when rx_ack_en is 1 and leaves SDA released when rx_ack_en is 0.
- R8: After releasing SCL, the block waits until it reads SCL high before it samples SDA or pulls SCL low again. Each SCL high time then lasts at least one quarter phase, so a slave holding SCL low stretches the bit without corrupting data.
- R9: done is a one-cycle pulse at the end of every accepted command. On a read rx_byte is valid in that cycle, and on a write slave_nack is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 3 | Command code (1 start, 2 repeated start, 3 stop, 4 write, 5 read) |
| tx_byte | input | 8 | Byte to send on a write command |
| rx_ack_en | input | 1 | On a read: 1 acknowledges the byte, 0 refuses it |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Byte captured by the last read |
| slave_nack | output | 1 | Acknowledge level sampled on the last write (1 = refused) |
| scl_i | input | 1 | SCL line level read back |
| sda_i | input | 1 | SDA line level read back |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench puts a behavioural slave on a wired-AND bus model. It runs:
- writes of 0xA6 and 0x3C, one acknowledged and one refused, which separate the bit order and acknowledge sampling;
- reads of 0x5A and 0xC3, which separate an acknowledge driven low from one left released;
- a stretched read of 0x96 and a stretched write of 0x71, with the slave holding SCL low for longer than two quarter phases, which exposes a master that samples or clocks blindly;
- starts from both an idle bus and a held-low clock, a stop, unknown command codes, and a stop offered while busy.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_START   = 3'd1,
    OP_RESTART = 3'd2,
    OP_STOP    = 3'd3,
    OP_WRITE   = 3'd4,
    OP_READ    = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COND,
    ST_BYTE
  } st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '1;
      else     sh <= {sh[STAGES-2:0], d[i]};
    end
    assign q[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/i2c_quarter_tick.sv
module i2c_quarter_tick #(
  parameter int unsigned QUARTER = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic hold,
  output logic tick
);
  localparam int unsigned CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;

  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == CW'(QUARTER - 1));

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (!hold)   cnt <= last ? '0 : cnt + 1'b1;
  end

  assign tick = run && !hold && last;
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned SCL_HZ      = 100_000,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              rx_ack_en,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              slave_nack,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int unsigned Q_RAW   = CLK_HZ / (4 * SCL_HZ);
  localparam int unsigned QUARTER = (Q_RAW < 1) ? 1 : Q_RAW;
  localparam int unsigned BIT_W   = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W);

  st_e               state;
  op_e               op_q;
  logic [1:0]        phase;
  logic [BIT_W-1:0]  bitn;
  logic [BYTE_W-1:0] txq, shq;
  logic              ackq, ack_cap;
  logic [1:0]        lines_s;
  logic              scl_s, sda_s, hold, step, op_ok;

  i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({sda_i, scl_i}), .q(lines_s)
  );
  assign scl_s = lines_s[0];
  assign sda_s = lines_s[1];

  // freeze the phase timer while a released SCL still reads low
  assign hold = (state != ST_IDLE) && !scl_oe && !scl_s;

  i2c_quarter_tick #(.QUARTER(QUARTER)) u_tick (
    .clk(clk), .rst(rst), .run(state != ST_IDLE), .hold(hold), .tick(step)
  );

  assign busy  = (state != ST_IDLE);
  assign op_ok = (cmd_op >= 3'd1) && (cmd_op <= 3'd5);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      op_q       <= OP_NONE;
      phase      <= 2'd0;
      bitn       <= '0;
      txq        <= '0;
      shq        <= '0;
      ackq       <= 1'b0;
      ack_cap    <= 1'b0;
      scl_oe     <= 1'b0;
      sda_oe     <= 1'b0;
      done       <= 1'b0;
      rx_byte    <= '0;
      slave_nack <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (cmd_valid && op_ok) begin
          op_q  <= op_e'(cmd_op);
          phase <= 2'd0;
          bitn  <= '0;
          txq   <= tx_byte;
          ackq  <= rx_ack_en;
          unique case (op_e'(cmd_op))
            OP_STOP:  begin state <= ST_COND; sda_oe <= 1'b1; end
            OP_WRITE: begin state <= ST_BYTE; sda_oe <= ~tx_byte[BYTE_W-1]; end
            OP_READ:  begin state <= ST_BYTE; sda_oe <= 1'b0; end
            default:  begin state <= ST_COND; sda_oe <= 1'b0; end
          endcase
        end
        ST_COND: if (step) begin
          phase <= phase + 2'd1;
          unique case (phase)
            2'd0: scl_oe <= 1'b0;
            2'd1: sda_oe <= (op_q != OP_STOP);
            2'd2: if (op_q != OP_STOP) scl_oe <= 1'b1;
            default: begin state <= ST_IDLE; done <= 1'b1; end
          endcase
        end
        ST_BYTE: if (step) begin
          phase <= phase + 2'd1;
          unique case (phase)
            2'd0: scl_oe <= 1'b0;
            2'd1: if (bitn == LAST_BIT) ack_cap <= sda_s;
                  else shq <= {shq[BYTE_W-2:0], sda_s};
            2'd2: scl_oe <= 1'b1;
            default: begin
              if (bitn == LAST_BIT) begin
                state <= ST_IDLE;
                done  <= 1'b1;
                if (op_q == OP_READ) rx_byte <= shq;
                else                 slave_nack <= ack_cap;
              end else begin
                bitn <= bitn + 1'b1;
                txq  <= {txq[BYTE_W-2:0], 1'b0};
                if (bitn == LAST_BIT - 1'b1) sda_oe <= (op_q == OP_READ) && ackq;
                else                         sda_oe <= (op_q == OP_WRITE) && !txq[BYTE_W-2];
              end
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && op_ok) |=> busy);
  assert_start_edge_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe) && state == ST_COND && op_q != OP_STOP) |-> (scl_s && !scl_oe));
  assert_stop_release_R4: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_STOP) |-> (!scl_oe && !sda_oe));
  assert_sda_scl_low_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BYTE && $past(state == ST_BYTE) && sda_oe != $past(sda_oe))
      |-> (scl_oe && $past(scl_oe)));
  assert_stretch_wait_R8: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(phase));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/tb_i2c_cmd_master.sv
`timescale 1ns/1ps
module tb_i2c_cmd_master;
  localparam int CLK_HZ = 200_000_000;
  localparam int SCL_HZ = 12_500_000;
  localparam int Q      = CLK_HZ / (4 * SCL_HZ);

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       cmd_valid = 1'b0, rx_ack_en = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] tx_byte = 8'h00, rx_byte;
  logic       busy, done, slave_nack, scl_oe, sda_oe;
  logic       slv_scl_low = 1'b0, slv_sda_low = 1'b0;
  logic       scl_bus, sda_bus;

  assign scl_bus = !(scl_oe || slv_scl_low);
  assign sda_bus = !(sda_oe || slv_sda_low);

  i2c_cmd_master #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .tx_byte(tx_byte), .rx_ack_en(rx_ack_en), .busy(busy), .done(done),
    .rx_byte(rx_byte), .slave_nack(slave_nack), .scl_i(scl_bus),
    .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { logic [2:0] op; logic [7:0] rx; logic nack; } exp_t;
  exp_t sb[$];
  exp_t cur;
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (sb.size() == 0) chk(1'b0, "R9 done without command", 1, 0);
        else begin
          cur = sb.pop_front();
          if (cur.op == 3'd5) chk(rx_byte == cur.rx, "R7 rx_byte at done", rx_byte, cur.rx);
          if (cur.op == 3'd4) chk(slave_nack == cur.nack, "R6 slave_nack at done", slave_nack, cur.nack);
        end
        if (prev_done) chk(1'b0, "R9 done longer than one cycle", 2, 1);
      end
      prev_done = done;
    end
  end

  // bus monitor and behavioural slave
  int   start_cnt = 0, stop_cnt = 0, fall_cnt = 0, hi_run = 0, min_hi = 1000;
  int   hold_cnt = 0, stretch_n = 0, stretch_seen = 0;
  int   slv_mode = 0;           // 0 idle, 1 receives a write, 2 sends a read
  logic slv_ack = 1'b0, mst_ack = 1'b1, scl_prev = 1'b1, sda_prev = 1'b1;
  logic [7:0] slv_data = 8'h00, cap = 8'h00;

  always @(negedge clk) begin
    if (!rst) begin
      if (scl_bus && scl_prev && sda_bus != sda_prev) begin
        if (!sda_bus) start_cnt++; else stop_cnt++;
      end
      if (scl_bus) hi_run++;
      if (scl_bus && !scl_prev) begin
        if (slv_mode == 1 && fall_cnt < 8) cap = {cap[6:0], sda_bus};
        if (slv_mode == 2 && fall_cnt == 8) mst_ack = sda_bus;
      end
      if (!scl_bus && scl_prev) begin
        if (hi_run < min_hi) min_hi = hi_run;
        hi_run = 0;
        fall_cnt++;
        if (slv_mode == 1) begin
          if (fall_cnt == 8) slv_sda_low = slv_ack;
          if (fall_cnt == 9) slv_sda_low = 1'b0;
        end else if (slv_mode == 2) begin
          if (fall_cnt < 8) slv_sda_low = !slv_data[7 - fall_cnt];
          else slv_sda_low = 1'b0;
        end
        if (slv_mode != 0 && stretch_n > 0) hold_cnt = stretch_n;
      end else if (hold_cnt > 0) begin
        hold_cnt--;
        if (!scl_oe) stretch_seen++;
      end
      slv_scl_low = (hold_cnt > 0);
      scl_prev = scl_bus;
      sda_prev = sda_bus;
    end
  end

  task automatic arm(input int mode, input logic [7:0] d, input logic a, input int st);
    slv_mode = mode; slv_data = d; slv_ack = a; stretch_n = st;
    fall_cnt = 0; cap = 8'h00; mst_ack = 1'b1; min_hi = 1000; stretch_seen = 0;
    slv_sda_low = (mode == 2) ? !d[7] : 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] tx, input logic a,
                       input logic [7:0] erx, input logic enack);
    @(negedge clk);
    sb.push_back('{op: op, rx: erx, nack: enack});
    cmd_valid = 1'b1; cmd_op = op; tx_byte = tx; rx_ack_en = a;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] tx, input logic a,
                         input logic [7:0] erx, input logic enack);
    issue(op, tx, a, erx, enack);
    wait_done();
  endtask

  int s0, p0;
  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1 lines released after reset", {scl_oe, sda_oe}, 0);
    chk(!busy && !done, "R1 busy/done low after reset", {busy, done}, 0);

    // R2: unknown codes at idle are ignored
    cmd_valid = 1'b1; cmd_op = 3'd0; @(negedge clk);
    cmd_op = 3'd7; @(negedge clk);
    cmd_valid = 1'b0; repeat (3) @(negedge clk);
    chk(!busy && scl_bus && sda_bus, "R2 unknown code ignored", {busy, scl_bus, sda_bus}, 3'b011);

    // R3: start from idle bus
    s0 = start_cnt;
    run_cmd(3'd1, 8'h00, 1'b0, 8'h00, 1'b0);
    chk(start_cnt == s0 + 1, "R3 start condition seen", start_cnt - s0, 1);
    chk(!scl_bus && !sda_bus, "R3 both lines low after start", {scl_bus, sda_bus}, 0);

    // R5/R6: acknowledged write
    s0 = start_cnt; p0 = stop_cnt;
    arm(1, 8'h00, 1'b1, 0);
    run_cmd(3'd4, 8'hA6, 1'b0, 8'h00, 1'b0);
    chk(cap == 8'hA6, "R5 write bits MSB first", cap, 8'hA6);
    chk(fall_cnt == 9, "R5 nine SCL pulses", fall_cnt, 9);
    chk(start_cnt == s0 && stop_cnt == p0, "R5 no condition inside byte", start_cnt + stop_cnt, s0 + p0);

    // R6: refused write
    arm(1, 8'h00, 1'b0, 0);
    run_cmd(3'd4, 8'h3C, 1'b0, 8'h00, 1'b1);
    chk(cap == 8'h3C, "R5 second write pattern", cap, 8'h3C);

    // R3: repeated start from held-low SCL
    arm(0, 8'h00, 1'b0, 0);
    s0 = start_cnt; p0 = stop_cnt;
    run_cmd(3'd2, 8'h00, 1'b0, 8'h00, 1'b0);
    chk(start_cnt == s0 + 1 && stop_cnt == p0, "R3 repeated start without stop", start_cnt - s0, 1);

    // R7: read with acknowledge
    arm(2, 8'h5A, 1'b0, 0);
    run_cmd(3'd5, 8'h00, 1'b1, 8'h5A, 1'b0);
    chk(mst_ack == 1'b0, "R7 master ack drives low", mst_ack, 0);

    // R8: stretched read
    arm(2, 8'h96, 1'b0, 30);
    run_cmd(3'd5, 8'h00, 1'b1, 8'h96, 1'b0);
    chk(stretch_seen > 0, "R8 slave stretch observed", stretch_seen, 1);
    chk(min_hi >= Q, "R8 SCL high time after stretch", min_hi, Q);
    chk(fall_cnt == 9, "R8 nine pulses under stretch", fall_cnt, 9);

    // R7: read with refusal
    arm(2, 8'hC3, 1'b0, 0);
    run_cmd(3'd5, 8'h00, 1'b0, 8'hC3, 1'b0);
    chk(mst_ack == 1'b1, "R7 master nack leaves SDA high", mst_ack, 1);

    // R4: stop
    arm(0, 8'h00, 1'b0, 0);
    p0 = stop_cnt;
    run_cmd(3'd3, 8'h00, 1'b0, 8'h00, 1'b0);
    chk(stop_cnt == p0 + 1, "R4 stop condition seen", stop_cnt - p0, 1);
    chk(scl_bus && sda_bus && !scl_oe && !sda_oe, "R4 lines released after stop",
        {scl_bus, sda_bus, scl_oe, sda_oe}, 4'b1100);

    // R8 + R2: stretched write with a stop offered while busy
    run_cmd(3'd1, 8'h00, 1'b0, 8'h00, 1'b0);
    arm(1, 8'h00, 1'b1, 30);
    p0 = stop_cnt;
    issue(3'd4, 8'h71, 1'b0, 8'h00, 1'b0);
    repeat (10) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd3; @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    repeat (3 * Q) @(negedge clk);
    chk(cap == 8'h71, "R8 stretched write data", cap, 8'h71);
    chk(min_hi >= Q, "R8 stretched write high time", min_hi, Q);
    chk(stop_cnt == p0 && !busy, "R2 command while busy ignored", stop_cnt - p0, 0);
    chk(sb.size() == 0, "R9 one done per command", sb.size(), 0);

    arm(0, 8'h00, 1'b0, 0);
    run_cmd(3'd3, 8'h00, 1'b0, 8'h00, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule